// File: doc/BRIEF.md
# Scaled-Index Load Unit

This unit executes one integer load at a time for a 64-bit core. A request carries the register field numbers, the two source register values, a two-bit scale field, an access size and a result mode. The unit adds the index value, shifted left by the scale field plus one, to a base value. It issues one read to memory and waits for the 8-byte response. It then shapes the loaded item into a 64-bit destination value by zero extension, sign extension or byte reversal.

In the update form the computed address is also written back to the base register, in the same writeback cycle as the destination. An update form whose base field is 0, or equals the destination field, is malformed. Such a request is flagged, makes no memory access and writes no register. Storage is big-endian: storage byte 0 is the most significant byte of the loaded item.

Top module: `sxl_load_unit`

## Requirements
- R1: The address is `base + (idx_val << (scale+1))` modulo 2^64. For a non-update request the base is zero when `ra_num` is 0 and `ra_val` otherwise. An update request always uses `ra_val` as the base.
- R2: For a well-formed update request, the writeback cycle asserts `wb_ra_en` together with `wb_rt_en`. In that cycle `wb_ra_num` = `ra_num` and `wb_ra_data` = the address. A non-update request never asserts `wb_ra_en`.
- R3: An update request with `ra_num`=0 or `ra_num`=`rt_num` raises `wb_bad` for exactly the cycle after acceptance. It asserts neither write enable and issues no memory request.
- R4: The size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. The item is the top N bytes of `mem_rdata`, with storage byte k at bits [63-8k -: 8]. In zero mode (mode 0, and also mode 3) the item sits in the low bits of `wb_rt_data` with the upper bits cleared.
- R5: In sign mode (mode 1) the bits above the item copy the item's most significant bit, for every size.
- R6: In reverse mode (mode 2) storage byte k lands in result byte k, where byte 0 is bits 7:0. The bits above the item are cleared, so a reversed 8-byte load fully swaps all eight bytes.
- R7: `mem_req` rises in the cycle after acceptance. It is held, with `mem_addr` and `mem_size` stable and `mem_size` equal to the request size code, until a cycle with `mem_ready` high.
- R8: After the request handshake the unit waits for `mem_rvalid`. It presents the writeback in the following cycle with `wb_rt_num` = `rt_num`.
- R9: `req_ready` is low from acceptance until the cycle after the writeback or malformed flag. A request offered during that time is not taken.
- R10: After reset `req_ready` is high and `mem_req`, `wb_rt_en`, `wb_ra_en` and `wb_bad` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Unit idle, request taken when valid |
| req_size | input | 2 | Access size code |
| req_mode | input | 2 | 0 zero, 1 sign, 2 reverse, 3 zero |
| req_upd | input | 1 | Update form |
| ra_num | input | 5 | Base register field |
| rt_num | input | 5 | Destination register field |
| req_scale | input | 2 | Index shift is this plus one |
| ra_val | input | 64 | Base register contents |
| idx_val | input | 64 | Index register contents |
| mem_req | output | 1 | Memory read request |
| mem_ready | input | 1 | Memory takes the request |
| mem_addr | output | 64 | Read address |
| mem_size | output | 2 | Read size code |
| mem_rvalid | input | 1 | Read data present |
| mem_rdata | input | 64 | Read data, storage byte 0 in bits 63:56 |
| wb_rt_en | output | 1 | Destination write |
| wb_rt_num | output | 5 | Destination register number |
| wb_rt_data | output | 64 | Shaped load result |
| wb_ra_en | output | 1 | Base register write (update form) |
| wb_ra_num | output | 5 | Base register number |
| wb_ra_data | output | 64 | Computed address |
| wb_bad | output | 1 | Malformed update request flag |

## Verification
The hardest case to reach from the ports is a stalled memory request: the address has to stay frozen while the memory withholds `mem_ready`. A second such case is a request offered while a load is already in flight. The bench holds `mem_ready` low for zero, one or two cycles, chosen by vector index. During each stall it checks that the request and address stay unchanged and that `req_ready` stays low. Address wrap-around is reached with a base near 2^64 and a small index. The malformed update cases are driven with a base field of 0 and with a base field equal to the destination field.

// File: rtl/sxl_pkg.sv
package sxl_pkg;
  localparam int XLEN = 64;
  localparam int NBYTE = XLEN / 8;

  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2, SZ_D = 2'd3} size_e;
  typedef enum logic [1:0] {MD_ZERO = 2'd0, MD_SIGN = 2'd1, MD_REV = 2'd2, MD_ZALT = 2'd3} mode_e;
  typedef enum logic [2:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_WB, ST_BAD} state_e;

  // base + (index << (scale+1)), wrapping at XLEN bits
  function automatic logic [XLEN-1:0] scaled_ea(logic [XLEN-1:0] base,
                                                logic [XLEN-1:0] idx,
                                                logic [1:0] scale);
    return base + (idx << ({1'b0, scale} + 3'd1));
  endfunction

  // shape the raw big-endian response into the destination value
  function automatic logic [XLEN-1:0] shape_load(logic [XLEN-1:0] raw,
                                                 logic [1:0] sz,
                                                 logic [1:0] md);
    int nb;
    logic [XLEN-1:0] item;
    logic [XLEN-1:0] rev;
    nb = 1 << sz;
    item = raw >> (XLEN - 8 * nb);
    rev = '0;
    for (int k = 0; k < NBYTE; k++)
      if (k < nb) rev[8*k +: 8] = raw[XLEN-1-8*k -: 8];
    if (md == MD_SIGN)
      for (int b = 0; b < XLEN; b++)
        if (b >= 8 * nb) item[b] = item[8*nb-1];
    return (md == MD_REV) ? rev : item;
  endfunction
endpackage

// File: rtl/sxl_agen.sv
module sxl_agen import sxl_pkg::*; #(
  parameter int RW = 5
) (
  input  logic            upd,
  input  logic [RW-1:0]   ra_num,
  input  logic [RW-1:0]   rt_num,
  input  logic [XLEN-1:0] ra_val,
  input  logic [XLEN-1:0] idx_val,
  input  logic [1:0]      scale,
  output logic [XLEN-1:0] ea,
  output logic            bad_form
);
  logic ra_zero;
  logic [XLEN-1:0] base;

  assign ra_zero  = (ra_num == '0);
  assign base     = (upd || !ra_zero) ? ra_val : '0;
  assign ea       = scaled_ea(base, idx_val, scale);
  assign bad_form = upd && (ra_zero || ra_num == rt_num);
endmodule

// File: rtl/sxl_fmt.sv
module sxl_fmt import sxl_pkg::*; (
  input  logic [XLEN-1:0] raw,
  input  logic [1:0]      size,
  input  logic [1:0]      mode,
  output logic [XLEN-1:0] shaped
);
  assign shaped = shape_load(raw, size, mode);
endmodule

// File: rtl/sxl_load_unit.sv
module sxl_load_unit import sxl_pkg::*; #(
  parameter int RW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [1:0]      req_size,
  input  logic [1:0]      req_mode,
  input  logic            req_upd,
  input  logic [RW-1:0]   ra_num,
  input  logic [RW-1:0]   rt_num,
  input  logic [1:0]      req_scale,
  input  logic [XLEN-1:0] ra_val,
  input  logic [XLEN-1:0] idx_val,
  output logic            mem_req,
  input  logic            mem_ready,
  output logic [XLEN-1:0] mem_addr,
  output logic [1:0]      mem_size,
  input  logic            mem_rvalid,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            wb_rt_en,
  output logic [RW-1:0]   wb_rt_num,
  output logic [XLEN-1:0] wb_rt_data,
  output logic            wb_ra_en,
  output logic [RW-1:0]   wb_ra_num,
  output logic [XLEN-1:0] wb_ra_data,
  output logic            wb_bad
);
  state_e          state_q;
  logic [XLEN-1:0] ea_d, ea_q, shaped_d, rt_data_q;
  logic [1:0]      size_q, mode_q;
  logic            upd_q, bad_d;
  logic [RW-1:0]   ra_q, rt_q;

  // named events for the checker
  logic accept, mem_fire, rsp_take;
  assign accept   = req_valid && req_ready;
  assign mem_fire = mem_req && mem_ready;
  assign rsp_take = (state_q == ST_WAIT) && mem_rvalid;

  sxl_agen #(.RW(RW)) u_agen (
    .upd(req_upd), .ra_num(ra_num), .rt_num(rt_num), .ra_val(ra_val),
    .idx_val(idx_val), .scale(req_scale), .ea(ea_d), .bad_form(bad_d)
  );

  sxl_fmt u_fmt (.raw(mem_rdata), .size(size_q), .mode(mode_q), .shaped(shaped_d));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      ea_q      <= '0;
      size_q    <= '0;
      mode_q    <= '0;
      upd_q     <= 1'b0;
      ra_q      <= '0;
      rt_q      <= '0;
      rt_data_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          ea_q    <= ea_d;
          size_q  <= req_size;
          mode_q  <= req_mode;
          upd_q   <= req_upd;
          ra_q    <= ra_num;
          rt_q    <= rt_num;
          state_q <= bad_d ? ST_BAD : ST_REQ;
        end
        ST_REQ:  if (mem_fire) state_q <= ST_WAIT;
        ST_WAIT: if (rsp_take) begin
          rt_data_q <= shaped_d;
          state_q   <= ST_WB;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign mem_req    = (state_q == ST_REQ);
  assign mem_addr   = ea_q;
  assign mem_size   = size_q;
  assign wb_rt_en   = (state_q == ST_WB);
  assign wb_rt_num  = rt_q;
  assign wb_rt_data = rt_data_q;
  assign wb_ra_en   = (state_q == ST_WB) && upd_q;
  assign wb_ra_num  = ra_q;
  assign wb_ra_data = ea_q;
  assign wb_bad     = (state_q == ST_BAD);
endmodule

// File: rtl/sxl_load_unit_chk.sv
module sxl_load_unit_chk #(
  parameter int RW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          accept,
  input logic          req_ready,
  input logic          mem_req,
  input logic          mem_ready,
  input logic [63:0]   mem_addr,
  input logic [1:0]    mem_size,
  input logic          wb_rt_en,
  input logic          wb_ra_en,
  input logic [RW-1:0] wb_ra_num,
  input logic [RW-1:0] wb_rt_num,
  input logic          wb_bad
);
  // R7
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_size));

  // R3
  bad_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_bad |-> !wb_rt_en && !wb_ra_en && !mem_req);

  // R2
  ra_write_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_ra_en |-> wb_rt_en && wb_ra_num != '0 && wb_ra_num != wb_rt_num);

  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  // R9
  one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, mem_req, wb_rt_en, wb_bad}));

  // R7
  req_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(accept));
endmodule

bind sxl_load_unit sxl_load_unit_chk #(.RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .req_ready(req_ready),
  .mem_req(mem_req), .mem_ready(mem_ready), .mem_addr(mem_addr),
  .mem_size(mem_size), .wb_rt_en(wb_rt_en), .wb_ra_en(wb_ra_en),
  .wb_ra_num(wb_ra_num), .wb_rt_num(wb_rt_num), .wb_bad(wb_bad)
);

// File: tb/sxl_load_unit_bench.sv
module sxl_load_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 17;

  typedef struct packed {
    logic [1:0]  sz;
    logic [1:0]  md;
    logic        upd;
    logic [4:0]  ra;
    logic [4:0]  rt;
    logic [1:0]  sh;
    logic [63:0] rav;
    logic [63:0] rbv;
    logic [63:0] data;
    logic [63:0] exp;
  } vec_t;

  localparam logic [63:0] DA = 64'hF1E2D3C4B5A69788;
  localparam logic [63:0] DB = 64'h1234567890ABCDEF;

  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd0, 1'b0, 5'd3, 5'd4, 2'd0, 64'h1000, 64'h10, DA, 64'h00000000000000F1},
    '{2'd0, 2'd1, 1'b0, 5'd0, 5'd4, 2'd3, 64'h5555, 64'h1,  DA, 64'hFFFFFFFFFFFFFFF1},
    '{2'd1, 2'd0, 1'b0, 5'd6, 5'd8, 2'd1, 64'h2000, 64'h3,  DA, 64'h000000000000F1E2},
    '{2'd1, 2'd1, 1'b0, 5'd6, 5'd8, 2'd2, 64'h2000, 64'h3,  DA, 64'hFFFFFFFFFFFFF1E2},
    '{2'd1, 2'd2, 1'b0, 5'd6, 5'd8, 2'd0, 64'h2000, 64'h7,  DA, 64'h000000000000E2F1},
    '{2'd2, 2'd0, 1'b0, 5'd1, 5'd2, 2'd1, 64'h40,   64'h9,  DA, 64'h00000000F1E2D3C4},
    '{2'd2, 2'd1, 1'b0, 5'd1, 5'd2, 2'd3, 64'h40,   64'h9,  DA, 64'hFFFFFFFFF1E2D3C4},
    '{2'd2, 2'd2, 1'b0, 5'd1, 5'd2, 2'd2, 64'h40,   64'h9,  DA, 64'h00000000C4D3E2F1},
    '{2'd3, 2'd0, 1'b0, 5'd5, 5'd2, 2'd0, 64'hFFFFFFFFFFFFFFF0, 64'h8, DA, 64'hF1E2D3C4B5A69788},
    '{2'd3, 2'd2, 1'b0, 5'd5, 5'd2, 2'd1, 64'h100,  64'h2,  DA, 64'h8897A6B5C4D3E2F1},
    '{2'd1, 2'd1, 1'b1, 5'd7, 5'd9, 2'd1, 64'h3000, 64'h4,  DB, 64'h0000000000001234},
    '{2'd2, 2'd1, 1'b1, 5'd2, 5'd1, 2'd0, 64'h8000, 64'h6,  DB, 64'h0000000012345678},
    '{2'd2, 2'd2, 1'b0, 5'd2, 5'd1, 2'd0, 64'h8000, 64'h6,  DB, 64'h0000000078563412},
    '{2'd3, 2'd2, 1'b1, 5'd4, 5'd3, 2'd3, 64'h10,   64'h1,  DB, 64'hEFCDAB9078563412},
    '{2'd0, 2'd1, 1'b0, 5'd4, 5'd3, 2'd0, 64'h10,   64'h1,  DB, 64'h0000000000000012},
    '{2'd2, 2'd3, 1'b0, 5'd4, 5'd3, 2'd0, 64'h10,   64'h1,  DA, 64'h00000000F1E2D3C4},
    '{2'd3, 2'd1, 1'b1, 5'd9, 5'd1, 2'd2, 64'hFFFFFFFFFFFFFFF8, 64'h1, DA, 64'hF1E2D3C4B5A69788}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_upd = 1'b0, mem_ready = 1'b0, mem_rvalid = 1'b0;
  logic [1:0] req_size = '0, req_mode = '0, req_scale = '0;
  logic [4:0] ra_num = '0, rt_num = '0;
  logic [63:0] ra_val = '0, idx_val = '0, mem_rdata = '0;
  logic req_ready, mem_req, wb_rt_en, wb_ra_en, wb_bad;
  logic [63:0] mem_addr, wb_rt_data, wb_ra_data;
  logic [1:0] mem_size;
  logic [4:0] wb_rt_num, wb_ra_num;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sxl_load_unit u_sxl_load_unit (.*);

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model_ea(vec_t v);
    logic [63:0] base, mult;
    base = (v.upd || v.ra != 0) ? v.rav : 64'd0;
    case (v.sh)
      2'd0: mult = 64'd2;
      2'd1: mult = 64'd4;
      2'd2: mult = 64'd8;
      default: mult = 64'd16;
    endcase
    return base + v.rbv * mult;
  endfunction

  task automatic offer(vec_t v);
    @(negedge clk);
    req_size = v.sz; req_mode = v.md; req_upd = v.upd; ra_num = v.ra; rt_num = v.rt;
    req_scale = v.sh; ra_val = v.rav; idx_val = v.rbv; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_good(vec_t v, int stall);
    logic [63:0] ea;
    ea = model_ea(v);
    offer(v);
    check("R7 mem_req raised", {63'd0, mem_req}, 64'd1);
    check("R1 address", mem_addr, ea);
    check("R7 size code", {62'd0, mem_size}, {62'd0, v.sz});
    for (int s = 0; s < stall; s++) begin
      req_valid = 1'b1;
      @(negedge clk);
      check("R7 held during stall", {63'd0, mem_req}, 64'd1);
      check("R7 address stable", mem_addr, ea);
      check("R9 busy, no accept", {63'd0, req_ready}, 64'd0);
    end
    req_valid = 1'b0;
    mem_ready = 1'b1;
    @(negedge clk);
    mem_ready = 1'b0;
    check("R7 request dropped", {63'd0, mem_req}, 64'd0);
    @(negedge clk);
    mem_rvalid = 1'b1; mem_rdata = v.data;
    @(negedge clk);
    mem_rvalid = 1'b0; mem_rdata = 64'hDEADBEEFDEADBEEF;
    check("R8 rt write", {63'd0, wb_rt_en}, 64'd1);
    check("R8 rt number", {59'd0, wb_rt_num}, {59'd0, v.rt});
    check("R4 R5 R6 result", wb_rt_data, v.exp);
    check("R2 ra write enable", {63'd0, wb_ra_en}, {63'd0, v.upd});
    if (v.upd) begin
      check("R2 ra data", wb_ra_data, ea);
      check("R2 ra number", {59'd0, wb_ra_num}, {59'd0, v.ra});
    end
    check("R9 busy in writeback", {63'd0, req_ready}, 64'd0);
    @(negedge clk);
    check("R9 ready again", {63'd0, req_ready}, 64'd1);
  endtask

  task automatic run_bad(vec_t v, string tag);
    offer(v);
    check({"R3 flag ", tag}, {63'd0, wb_bad}, 64'd1);
    check({"R3 no rt write ", tag}, {63'd0, wb_rt_en}, 64'd0);
    check({"R3 no ra write ", tag}, {63'd0, wb_ra_en}, 64'd0);
    check({"R3 no mem req ", tag}, {63'd0, mem_req}, 64'd0);
    @(negedge clk);
    check({"R3 flag one cycle ", tag}, {63'd0, wb_bad}, 64'd0);
    check({"R3 no mem req later ", tag}, {63'd0, mem_req}, 64'd0);
    check({"R9 ready after flag ", tag}, {63'd0, req_ready}, 64'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    vec_t b;
    repeat (3) @(negedge clk);
    // R10
    check("R10 ready in reset", {63'd0, req_ready}, 64'd1);
    check("R10 idle outputs", {60'd0, mem_req, wb_rt_en, wb_ra_en, wb_bad}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 idle after reset", {60'd0, mem_req, wb_rt_en, wb_ra_en, wb_bad}, 64'd0);

    for (int i = 0; i < NV; i++) run_good(VECS[i], i % 3);

    b = VECS[10]; b.ra = 5'd0;
    run_bad(b, "ra zero");
    b = VECS[11]; b.ra = 5'd6; b.rt = 5'd6;
    run_bad(b, "ra equals rt");
    // a non-update request with ra field equal to rt is well formed
    b = VECS[5]; b.ra = 5'd2; b.rt = 5'd2;
    run_good(b, 1);

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule